// File: doc/BRIEF.md
# Trigger Header Injector

This block sits at the central trigger source of a readout network. A local trigger event, with its tag and code, becomes one 64-bit broadcast header word on the trigger channel, which outranks all other traffic on the link. The word is built and registered when the trigger is taken. It is then offered to the link through a valid/ready handshake. If the link is still carrying another transfer, the word waits in a single holding register and leaves in the first cycle the link accepts it.

Once a trigger is taken, the channel is locked. The lock is visible on a busy output and refuses further triggers. It is freed only when the downstream release comes back after the word has gone out. A programmable watchdog raises an error if that release is late.

The block also drains the reply path on every cycle, so replies never back up. It keeps the most recent error pattern that a reply carried.

Top module: `trig_hdr_injector`

## Requirements
- R1: `trig_accept` is high exactly when `trig_valid` is high and `lock_busy` is low; in the cycle after an accept, `lock_busy` is high.
- R2: The header word has fixed fields: bits 63:60 channel ID 4'b0001, bit 59 parity 0, bits 58:56 type 3'b011 (trigger message), bits 55:40 source 16'h0000, bits 39:24 target 16'hFFFF.
- R3: Header bits 23:0 carry the trigger: code in bits CODE_W-1:0, tag in the next TAG_W bits, and zeros above them. These values are captured in the accept cycle.
- R4: `tx_valid` rises in the cycle after an accept. While `tx_ready` is low, `tx_valid` and `tx_word` hold steady. The word is transferred in the first cycle with `tx_valid` and `tx_ready` both high, and `tx_valid` is low in the next cycle.
- R5: While `lock_busy` is high, `trig_valid` is ignored: `trig_accept` stays low and the tag and code of the pending word do not change.
- R6: `release_in` while the word is still pending has no effect. `release_in` after the transfer clears `lock_busy` in the next cycle.
- R7: Once the word is transferred, `timeout_err` goes high after `timeout_limit` consecutive cycles without a release. It stays high until the next accept clears it. A limit of 0 disables it.
- R8: `reply_ready` is always high. `err_pattern` takes `reply_err` in the cycle after any cycle with `reply_valid` high, and holds its value otherwise.
- R9: After reset, `lock_busy`, `tx_valid`, `timeout_err` and `err_pattern` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Local trigger event request |
| trig_tag | input | TAG_W | Trigger tag |
| trig_code | input | CODE_W | Trigger code |
| trig_accept | output | 1 | Trigger taken this cycle |
| tx_valid | output | 1 | Header word offered to link |
| tx_word | output | 64 | Header word |
| tx_ready | input | 1 | Link can take the word this cycle |
| lock_busy | output | 1 | Trigger channel locked |
| release_in | input | 1 | Downstream lock release |
| timeout_limit | input | TO_W | Release watchdog limit in cycles, 0 disables |
| timeout_err | output | 1 | Release watchdog expired |
| reply_valid | input | 1 | Reply word present |
| reply_err | input | ERR_W | Error pattern carried by the reply |
| reply_ready | output | 1 | Reply accepted |
| err_pattern | output | ERR_W | Last reply error pattern |

## Verification
The properties leave `tx_ready`, `release_in` and `reply_valid` unconstrained on every cycle. They do assume that `timeout_limit` does not change while the lock is held. They also assume that `release_in` only matters once the word has left. The stimulus changes inputs only just after a rising edge. It changes `timeout_limit` only while the channel is idle, and it mixes directed sequences (held word, early release, watchdog expiry, disabled watchdog) with a long stretch of random pulses on all handshake inputs.

// File: rtl/trig_inj_pkg.sv
package trig_inj_pkg;
   localparam int WORD_W   = 64;
   localparam int DATA_W   = 24;
   localparam logic [3:0]  CHAN_ID  = 4'h1;
   localparam logic        PAR_BIT  = 1'b0;
   localparam logic [2:0]  TYPE_TRG = 3'b011;
   localparam logic [15:0] SRC_ADDR = 16'h0000;
   localparam logic [15:0] DST_BCST = 16'hFFFF;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_WAIT = 2'd2
   } inj_state_t;
endpackage

// File: rtl/trig_hdr_build.sv
module trig_hdr_build
   import trig_inj_pkg::*;
#(
   parameter int TAG_W  = 8,
   parameter int CODE_W = 4
) (
   input  logic [TAG_W-1:0]  tag,
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] word
);
   localparam int TC_W  = TAG_W + CODE_W;
   localparam int PAD_W = DATA_W - TC_W;

   logic [DATA_W-1:0] data_f;

   generate
      if (PAD_W > 0) begin : g_pad
         assign data_f = {{PAD_W{1'b0}}, tag, code};
      end else begin : g_full
         assign data_f = {tag, code};
      end
   endgenerate

   assign word = {CHAN_ID, PAR_BIT, TYPE_TRG, SRC_ADDR, DST_BCST, data_f};
endmodule

// File: rtl/trig_lock_fsm.sv
module trig_lock_fsm
   import trig_inj_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_valid,
   input  logic       tx_ready,
   input  logic       release_in,
   output logic       accept,
   output logic       pend,
   output logic       waiting,
   output logic       locked
);
   inj_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (trig_valid) st_d = ST_PEND;
         ST_PEND: if (tx_ready)   st_d = ST_WAIT;
         ST_WAIT: if (release_in) st_d = ST_IDLE;
         default:                 st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign accept  = (st_q == ST_IDLE) && trig_valid;
   assign pend    = (st_q == ST_PEND);
   assign waiting = (st_q == ST_WAIT);
   assign locked  = (st_q != ST_IDLE);
endmodule

// File: rtl/trig_rel_timer.sv
module trig_rel_timer #(
   parameter int TO_W        = 16,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            clear,
   input  logic            release_in,
   input  logic [TO_W-1:0] limit,
   output logic            expired
);
   generate
      if (USE_TIMEOUT) begin : g_timer
         localparam logic [TO_W-1:0] CNT_MAX = {TO_W{1'b1}};
         logic [TO_W-1:0] cnt_q;
         logic            exp_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               exp_q <= 1'b0;
            end else begin
               if (clear) exp_q <= 1'b0;
               if (!run) begin
                  cnt_q <= '0;
               end else if (!release_in) begin
                  if ((limit != '0) && (cnt_q == limit - 1'b1)) exp_q <= 1'b1;
                  if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
               end
            end
         end
         assign expired = exp_q;
      end else begin : g_none
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, run, clear, release_in, limit};
         assign expired   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/trig_hdr_injector.sv
module trig_hdr_injector
   import trig_inj_pkg::*;
#(
   parameter int TAG_W       = 8,
   parameter int CODE_W      = 4,
   parameter int ERR_W       = 16,
   parameter int TO_W        = 16,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   input  logic [TAG_W-1:0]  trig_tag,
   input  logic [CODE_W-1:0] trig_code,
   output logic              trig_accept,
   output logic              tx_valid,
   output logic [63:0]       tx_word,
   input  logic              tx_ready,
   output logic              lock_busy,
   input  logic              release_in,
   input  logic [TO_W-1:0]   timeout_limit,
   output logic              timeout_err,
   input  logic              reply_valid,
   input  logic [ERR_W-1:0]  reply_err,
   output logic              reply_ready,
   output logic [ERR_W-1:0]  err_pattern
);
   generate
      if (TAG_W + CODE_W > DATA_W) begin : g_bad_tc
         $error("tag plus code wider than header data field");
      end
      if (WORD_W != 64) begin : g_bad_word
         $error("header word must be 64 bits");
      end
      if (TO_W < 1 || ERR_W < 1) begin : g_bad_w
         $error("timeout and error widths must be positive");
      end
   endgenerate

   logic              acc;
   logic              pend;
   logic              waiting;
   logic              locked;
   logic [WORD_W-1:0] built;
   logic [WORD_W-1:0] hold_q;
   logic [ERR_W-1:0]  err_q;

   trig_lock_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_valid (trig_valid),
      .tx_ready   (tx_ready),
      .release_in (release_in),
      .accept     (acc),
      .pend       (pend),
      .waiting    (waiting),
      .locked     (locked)
   );

   trig_hdr_build #(.TAG_W(TAG_W), .CODE_W(CODE_W)) u_build (
      .tag  (trig_tag),
      .code (trig_code),
      .word (built)
   );

   trig_rel_timer #(.TO_W(TO_W), .USE_TIMEOUT(USE_TIMEOUT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (waiting),
      .clear      (acc),
      .release_in (release_in),
      .limit      (timeout_limit),
      .expired    (timeout_err)
   );

   // single-entry holding register: captured on accept, held until link takes it
   always_ff @(posedge clk) begin
      if (!rst_n)   hold_q <= '0;
      else if (acc) hold_q <= built;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           err_q <= '0;
      else if (reply_valid) err_q <= reply_err;
   end

   assign trig_accept = acc;
   assign tx_valid    = pend;
   assign tx_word     = hold_q;
   assign lock_busy   = locked;
   assign reply_ready = 1'b1;
   assign err_pattern = err_q;
endmodule

// File: rtl/trig_hdr_injector_chk.sv
module trig_hdr_injector_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        trig_valid,
   input logic        trig_accept,
   input logic        tx_valid,
   input logic [63:0] tx_word,
   input logic        tx_ready,
   input logic        lock_busy,
   input logic        release_in
);
   p_lock_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      trig_accept |=> lock_busy);

   p_fixed_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_word[63:24] == {4'h1, 1'b0, 3'b011, 16'h0000, 16'hFFFF}));

   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word)));

   p_single_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_valid);

   p_no_accept_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_busy && trig_valid) |-> !trig_accept);

   p_lock_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_busy && (tx_valid || !release_in)) |=> lock_busy);

   p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_busy && !tx_valid && release_in) |=> !lock_busy);
endmodule

bind trig_hdr_injector trig_hdr_injector_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trig_valid  (trig_valid),
   .trig_accept (trig_accept),
   .tx_valid    (tx_valid),
   .tx_word     (tx_word),
   .tx_ready    (tx_ready),
   .lock_busy   (lock_busy),
   .release_in  (release_in)
);

// File: tb/sim_trig_hdr_injector.sv
`timescale 1ns/1ps
module sim_trig_hdr_injector;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        trig_valid;
   logic [7:0]  trig_tag;
   logic [3:0]  trig_code;
   logic        trig_accept;
   logic        tx_valid;
   logic [63:0] tx_word;
   logic        tx_ready;
   logic        lock_busy;
   logic        release_in;
   logic [15:0] timeout_limit;
   logic        timeout_err;
   logic        reply_valid;
   logic [15:0] reply_err;
   logic        reply_ready;
   logic [15:0] err_pattern;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   trig_hdr_injector u0 (
      .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_tag(trig_tag),
      .trig_code(trig_code), .trig_accept(trig_accept), .tx_valid(tx_valid),
      .tx_word(tx_word), .tx_ready(tx_ready), .lock_busy(lock_busy),
      .release_in(release_in), .timeout_limit(timeout_limit),
      .timeout_err(timeout_err), .reply_valid(reply_valid), .reply_err(reply_err),
      .reply_ready(reply_ready), .err_pattern(err_pattern)
   );

   // reference model: 0 idle, 1 word pending, 2 waiting for release
   int          m_st;
   int          m_cnt;
   logic [63:0] m_word;
   logic        m_terr;
   logic [15:0] m_err;

   function automatic logic [63:0] mk_word(logic [7:0] t, logic [3:0] c);
      return {4'h1, 1'b0, 3'b011, 16'h0000, 16'hFFFF, 12'h000, t, c};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_word = '0; m_terr = 1'b0; m_err = '0;
      end else begin
         if (reply_valid) m_err = reply_err;
         case (m_st)
            0: if (trig_valid) begin
                  m_st = 1; m_word = mk_word(trig_tag, trig_code); m_terr = 1'b0;
               end
            1: if (tx_ready) begin m_st = 2; m_cnt = 0; end
            default: if (release_in) m_st = 0;
                     else begin
                        m_cnt++;
                        if (timeout_limit != 0 && m_cnt == int'(timeout_limit)) m_terr = 1'b1;
                     end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         chk("R1 accept", trig_accept, (m_st == 0) && trig_valid);
         chk("R5 lock_busy", lock_busy, m_st != 0);
         chk("R4 tx_valid", tx_valid, m_st == 1);
         if (m_st == 1) chk("R2/R3 tx_word", tx_word, m_word);
         chk("R7 timeout_err", timeout_err, m_terr);
         chk("R8 err_pattern", err_pattern, m_err);
         chk("R8 reply_ready", reply_ready, 1'b1);
      end
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic idle_inputs();
      trig_valid = 0; tx_ready = 0; release_in = 0; reply_valid = 0;
   endtask

   initial begin
      rst_n = 0; trig_tag = 0; trig_code = 0; timeout_limit = 0; reply_err = 0;
      idle_inputs();
      tick(3);
      @(negedge clk);
      // R9 reset state
      chk("R9 lock_busy", lock_busy, 0);
      chk("R9 tx_valid", tx_valid, 0);
      chk("R9 timeout_err", timeout_err, 0);
      chk("R9 err_pattern", err_pattern, 0);
      @(posedge clk); #1; rst_n = 1;
      tick(2);

      // R4 immediate send with link free
      trig_valid = 1; trig_tag = 8'hA5; trig_code = 4'h3; tx_ready = 1;
      tick(1); trig_valid = 0;
      @(negedge clk);
      chk("R3 data field", tx_word[23:0], 24'h000A53);
      chk("R2 target", tx_word[39:24], 16'hFFFF);
      tick(1); tx_ready = 0;
      tick(2); release_in = 1; tick(1); release_in = 0;
      tick(1);

      // R4/R5 link busy: word held, later triggers ignored
      trig_valid = 1; trig_tag = 8'h3C; trig_code = 4'hE;
      tick(1);
      trig_tag = 8'hFF; trig_code = 4'h0;          // locked now: must be ignored
      tick(3);
      @(negedge clk);
      chk("R5 held tag/code", tx_word[11:0], 12'h3CE);
      // R6 early release while pending ignored
      @(posedge clk); #1; release_in = 1;
      tick(1); release_in = 0;
      @(negedge clk);
      chk("R6 early release ignored", lock_busy, 1);
      @(posedge clk); #1; trig_valid = 0; tx_ready = 1;
      tick(1); tx_ready = 0;
      tick(2); release_in = 1; tick(1); release_in = 0;
      @(negedge clk);
      chk("R6 release frees", lock_busy, 0);

      // R7 watchdog with limit 5
      @(posedge clk); #1; timeout_limit = 16'd5;
      trig_valid = 1; trig_tag = 8'h11; trig_code = 4'h1; tx_ready = 1;
      tick(1); trig_valid = 0;
      tick(1); tx_ready = 0;
      tick(4);
      @(negedge clk); chk("R7 not yet", timeout_err, 0);
      tick(1);
      @(negedge clk); chk("R7 expired", timeout_err, 1);
      @(posedge clk); #1; release_in = 1; tick(1); release_in = 0;
      trig_valid = 1; tick(1); trig_valid = 0;
      @(negedge clk); chk("R7 cleared on accept", timeout_err, 0);
      @(posedge clk); #1; tx_ready = 1; tick(1); tx_ready = 0;
      tick(2); release_in = 1; tick(1); release_in = 0;

      // R7 limit 0 disables
      timeout_limit = 16'd0;
      trig_valid = 1; tx_ready = 1; tick(1); trig_valid = 0; tick(1); tx_ready = 0;
      tick(20);
      @(negedge clk); chk("R7 disabled", timeout_err, 0);
      @(posedge clk); #1; release_in = 1; tick(1); release_in = 0;

      // R8 reply capture
      reply_valid = 1; reply_err = 16'hBEEF; tick(1);
      reply_valid = 0; reply_err = 16'h1234; tick(2);
      @(negedge clk); chk("R8 err held", err_pattern, 16'hBEEF);

      // random mix
      @(posedge clk); #1; timeout_limit = 16'd7;
      for (int i = 0; i < 600; i++) begin
         trig_valid  = ($urandom % 3) == 0;
         trig_tag    = 8'($urandom);
         trig_code   = 4'($urandom);
         tx_ready    = ($urandom % 3) != 0;
         release_in  = ($urandom % 6) == 0;
         reply_valid = ($urandom % 4) == 0;
         reply_err   = 16'($urandom);
         if (!lock_busy && !trig_valid && (i % 50) == 0) timeout_limit = 16'(3 + $urandom % 8);
         tick(1);
      end
      idle_inputs();
      tick(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 50000 && !done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected<=50000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule